// File: doc/BRIEF.md
# Resizable BAR Configuration Register Block

This block holds the configuration-space state of a single endpoint memory BAR. A build-time parameter selects how the BAR gets its size. With a fixed mask, the size is a parameter. With a programmable mask, firmware writes (size − 1) into a shadow location. In resizable mode, the block carries a resizable-BAR extended capability, a capability word and a control word, and derives the address mask from the selected size in hardware. The mask is never written directly in that mode.

Three groups of signals drive it:

- A configuration read/write port reaches the BAR words and the two capability words. Reads are combinational.
- A shadow write port reaches the mask locations.
- A read-only-write-enable input unlocks the fields that are read-only from the host side.

A small state machine runs the resizable flow. It has three states:

- `ST_OFF`: the BAR is disabled and its mask is zero.
- `ST_SIZING`: a one-cycle recompute of the selected size.
- `ST_LIVE`: the BAR decodes with its mask.

The state machine has these transitions:

- `ST_OFF` moves to `ST_SIZING` on any resize trigger. A resize trigger is an unlocked write of the capability word, an unlocked write of the control word, or an unlocked shadow-low write. In programmable mode, `ST_OFF` instead moves to `ST_LIVE` on an unlocked shadow-low write with bit 0 set.
- `ST_SIZING` stays in `ST_SIZING` if another trigger arrives. Otherwise it moves to `ST_LIVE` when the BAR is enabled and some size is supported, and to `ST_OFF` when it is not.
- `ST_LIVE` moves back to `ST_SIZING` on a trigger. In programmable mode, `ST_LIVE` moves to `ST_OFF` on an unlocked shadow-low write with bit 0 clear.
- In fixed mode the machine leaves reset in `ST_LIVE` and stays there.

Top module: `rbar_cfg_regs`

## Requirements
- R1: With SCHEME=0 (fixed), the BAR is enabled from reset. `bar_mask` equals FIXED_MASK, with its upper half used only when the BAR is 64-bit. Shadow writes have no effect.
- R2: With SCHEME=1 (programmable), an unlocked shadow write to `shd_sel`=0 sets the low mask word, and bit 0 of that word enables the BAR. An unlocked write to `shd_sel`=1 sets the high mask word, which applies only to a 64-bit BAR. Shadow writes without read-only-write-enable are ignored.
- R3: With SCHEME=2 (resizable), bit 0 of an unlocked shadow-low write is only the BAR enable, and the mask never takes the shadow value.
- R4: Capability word (`cfg_addr`=2): bits 31:4 are supported-size flags. Bit k means 2^(k+16) bytes, so bit 4 is 1 MB and bit 31 is 128 TB. Bits 3:0 read 0. Writes take effect only with `ro_wr_en` high.
- R5: Control word (`cfg_addr`=3) fields:
  - Bits 31:16 are supported-size flags for sizes index 28 to 43 (256 TB to 8 EB), writable only with `ro_wr_en` high.
  - Bits 13:8 hold the selected size index, where size = 1 MB × 2^index.
  - Bits 7:5 hold the count of resizable BARs, and bits 2:0 hold the BAR index. Both are read-only.
  - All other bits read 0.
- R6: A resize trigger moves the machine to sizing. On the following edge, the selected index becomes the lowest supported index. The BAR goes live if it is enabled and some size is supported; otherwise it stays disabled. Results are visible after the second edge following the write.
- R7: In resizable mode, a live BAR has `bar_mask` = 2^(20+index) − 1. The BAR low word reads the written base with the masked bits cleared, ORed with attribute bits 3:0. Attribute bits change only on an unlocked write.
- R8: Attribute bits 2:1 = 2'b10 mark the BAR as 64-bit, and the upper mask half then applies. Otherwise the upper mask half is zero and the BAR high word (`cfg_addr`=1) reads 0.
- R9: A control-word write with `ro_wr_en` low, while live, sets the selected index on the next edge if that size is supported. A write naming an unsupported or out-of-range size is ignored.
- R10: A disabled BAR drives `bar_enabled`=0 and `bar_mask`=0, and both BAR words read 0.
- R11: After reset:
  - In resizable and programmable modes, the BAR is disabled and all flags, attributes and bases are zero.
  - The capability word reads 0.
  - The control word shows only the count and index fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_wr_en | input | 1 | Unlocks read-only fields for writes |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word select: 0 BAR low, 1 BAR high, 2 capability, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| shd_wr_en | input | 1 | Shadow (mask) write strobe |
| shd_sel | input | 1 | Shadow word select: 0 low, 1 high |
| shd_wdata | input | 32 | Shadow write data |
| bar_enabled | output | 1 | BAR is live |
| bar_mask | output | 64 | Size mask (size − 1 form) |

## Verification
Each result has its own due cycle:

- Attribute, base, programmable-mask and selected-size writes show on the outputs right after the edge that takes them.
- A capability, control-unlock or enable write in resizable mode first moves the machine to sizing. The new mask and selected size then appear after the second edge.

The bench model advances on each rising edge in the same way: a resize trigger sets a pending flag, and the flag is resolved one edge later. The model is compared with all three scheme variants 2 ns after every rising edge. At that point the registered state has settled, and the read address and write inputs for the next edge are not yet driven.

// File: rtl/rbar_pkg.sv
package rbar_pkg;
    localparam int SCH_FIXED  = 0;
    localparam int SCH_PROG   = 1;
    localparam int SCH_RESIZE = 2;

    localparam logic [1:0] REG_BAR_LO  = 2'd0;
    localparam logic [1:0] REG_BAR_HI  = 2'd1;
    localparam logic [1:0] REG_RSZ_CAP = 2'd2;
    localparam logic [1:0] REG_RSZ_CTL = 2'd3;

    localparam int CAP_FLAGS  = 28;
    localparam int CTL_FLAGS  = 16;
    localparam int NUM_SIZES  = CAP_FLAGS + CTL_FLAGS;
    localparam int SEL_W      = 6;
    localparam int MIN_LOG2   = 20;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SIZING = 2'd1,
        ST_LIVE   = 2'd2
    } bar_state_e;
endpackage

// File: rtl/rbar_lowest_pick.sv
module rbar_lowest_pick #(
    parameter int N = 44,
    parameter int W = 6
) (
    input  logic [N-1:0] flags_i,
    output logic [W-1:0] idx_o,
    output logic         any_o
);
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags_i[i]) begin
                idx_o = W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rbar_mask_gen.sv
module rbar_mask_gen #(
    parameter int SEL_W    = 6,
    parameter int BASE_LOG = 20,
    parameter int MASK_W   = 64
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [MASK_W-1:0] mask_o
);
    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        assign mask_o[b] = (b < BASE_LOG + int'(sel_i));
    end
endmodule

// File: rtl/rbar_cfg_regs.sv
module rbar_cfg_regs
    import rbar_pkg::*;
#(
    parameter int          SCHEME        = 2,
    parameter logic [63:0] FIXED_MASK    = 64'h0000_0000_0000_FFFF,
    parameter int          BAR_INDEX     = 0,
    parameter int          RSZ_BAR_COUNT = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ro_wr_en,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        shd_wr_en,
    input  logic        shd_sel,
    input  logic [31:0] shd_wdata,
    output logic        bar_enabled,
    output logic [63:0] bar_mask
);
    localparam bit IS_FIXED = (SCHEME == SCH_FIXED);
    localparam bit IS_PROG  = (SCHEME == SCH_PROG);
    localparam bit IS_RSZ   = (SCHEME == SCH_RESIZE);
    localparam bar_state_e RESET_STATE = IS_FIXED ? ST_LIVE : ST_OFF;

    bar_state_e            state_q, state_d;
    logic [3:0]            attr_q;
    logic [27:0]           base_lo_q;
    logic [31:0]           base_hi_q;
    logic [31:0]           shd_lo_q, shd_hi_q;
    logic                  rsz_en_q;
    logic [NUM_SIZES-1:0]  sup_q;
    logic [SEL_W-1:0]      sel_q;

    logic [SEL_W-1:0]      pick_idx;
    logic                  pick_any;
    logic [63:0]           rsz_mask;
    logic [63:0]           sup_pad;
    logic [63:0]           raw_mask;
    logic                  is64;

    logic wr_cap, wr_ctl_ro, wr_ctl_sel, shd_lo_wr, shd_hi_wr, kick, req_ok;
    logic [SEL_W-1:0] req_sel;

    assign is64      = (attr_q[2:1] == 2'b10);
    assign sup_pad   = {{(64-NUM_SIZES){1'b0}}, sup_q};
    assign wr_cap    = IS_RSZ && cfg_wr_en && ro_wr_en && (cfg_addr == REG_RSZ_CAP);
    assign wr_ctl_ro = IS_RSZ && cfg_wr_en && ro_wr_en && (cfg_addr == REG_RSZ_CTL);
    assign wr_ctl_sel = IS_RSZ && cfg_wr_en && !ro_wr_en && (cfg_addr == REG_RSZ_CTL)
                        && (state_q == ST_LIVE);
    assign shd_lo_wr = shd_wr_en && ro_wr_en && !shd_sel;
    assign shd_hi_wr = shd_wr_en && ro_wr_en && shd_sel;
    assign kick      = wr_cap || wr_ctl_ro || (IS_RSZ && shd_lo_wr);
    assign req_sel   = cfg_wdata[13:8];
    assign req_ok    = sup_pad[req_sel];

    rbar_lowest_pick #(.N(NUM_SIZES), .W(SEL_W)) pick_i (
        .flags_i (sup_q),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    rbar_mask_gen #(.SEL_W(SEL_W), .BASE_LOG(MIN_LOG2), .MASK_W(64)) mgen_i (
        .sel_i  (sel_q),
        .mask_o (rsz_mask)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (kick)                                      state_d = ST_SIZING;
                else if (IS_PROG && shd_lo_wr && shd_wdata[0]) state_d = ST_LIVE;
            end
            ST_SIZING: begin
                if (kick)                        state_d = ST_SIZING;
                else if (rsz_en_q && pick_any)   state_d = ST_LIVE;
                else                             state_d = ST_OFF;
            end
            ST_LIVE: begin
                if (kick)                                       state_d = ST_SIZING;
                else if (IS_PROG && shd_lo_wr && !shd_wdata[0]) state_d = ST_OFF;
            end
            default: state_d = RESET_STATE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_q    <= '0;
            base_lo_q <= '0;
            base_hi_q <= '0;
            shd_lo_q  <= '0;
            shd_hi_q  <= '0;
            rsz_en_q  <= 1'b0;
            sup_q     <= '0;
            sel_q     <= '0;
        end else begin
            if (cfg_wr_en && cfg_addr == REG_BAR_LO) begin
                base_lo_q <= cfg_wdata[31:4];
                if (ro_wr_en) attr_q <= cfg_wdata[3:0];
            end
            if (cfg_wr_en && cfg_addr == REG_BAR_HI) base_hi_q <= cfg_wdata;
            if (shd_lo_wr) begin
                shd_lo_q <= shd_wdata;
                rsz_en_q <= shd_wdata[0];
            end
            if (shd_hi_wr) shd_hi_q <= shd_wdata;
            if (wr_cap)    sup_q[CAP_FLAGS-1:0] <= cfg_wdata[31:4];
            if (wr_ctl_ro) sup_q[NUM_SIZES-1:CAP_FLAGS] <= cfg_wdata[31:16];
            if (state_q == ST_SIZING && pick_any) sel_q <= pick_idx;
            else if (wr_ctl_sel && req_ok)        sel_q <= req_sel;
        end
    end

    // Outputs
    always_comb begin
        unique case (SCHEME)
            SCH_FIXED: raw_mask = FIXED_MASK;
            SCH_PROG:  raw_mask = {shd_hi_q, shd_lo_q};
            default:   raw_mask = rsz_mask;
        endcase
        bar_enabled = (state_q == ST_LIVE);
        bar_mask    = bar_enabled ? {(is64 ? raw_mask[63:32] : 32'd0), raw_mask[31:0]} : 64'd0;
        unique case (cfg_addr)
            REG_BAR_LO:  cfg_rdata = bar_enabled
                             ? (({base_lo_q, 4'b0000} & ~bar_mask[31:0]) | {28'd0, attr_q})
                             : 32'd0;
            REG_BAR_HI:  cfg_rdata = (bar_enabled && is64) ? (base_hi_q & ~bar_mask[63:32]) : 32'd0;
            REG_RSZ_CAP: cfg_rdata = IS_RSZ ? {sup_q[CAP_FLAGS-1:0], 4'b0000} : 32'd0;
            default:     cfg_rdata = IS_RSZ ? {sup_q[NUM_SIZES-1:CAP_FLAGS], 2'b00, sel_q,
                                               3'(RSZ_BAR_COUNT), 2'b00, 3'(BAR_INDEX)} : 32'd0;
        endcase
    end
endmodule

// File: rtl/rbar_cfg_checker.sv
module rbar_cfg_checker
    import rbar_pkg::*;
#(
    parameter int SCHEME = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ro_wr_en,
    input logic                 cfg_wr_en,
    input logic [1:0]           cfg_addr,
    input logic [31:0]          cfg_wdata,
    input logic                 bar_enabled,
    input logic [63:0]          bar_mask,
    input bar_state_e           state_q,
    input logic [NUM_SIZES-1:0] sup_q,
    input logic [SEL_W-1:0]     sel_q
);
    logic [63:0] flags64;
    assign flags64 = {{(64-NUM_SIZES){1'b0}}, sup_q};

    // R4: capability flags hold without the unlock
    a_r4_cap_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !ro_wr_en && cfg_addr == REG_RSZ_CAP) |=> $stable(sup_q[CAP_FLAGS-1:0]));

    // R5: upper flags hold without the unlock
    a_r5_ctl_flags_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !ro_wr_en && cfg_addr == REG_RSZ_CTL) |=> $stable(sup_q[NUM_SIZES-1:CAP_FLAGS]));

    // R6: a live resizable BAR always selects a supported size
    a_r6_live_supported: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_RESIZE && state_q == ST_LIVE) |-> flags64[sel_q]);

    // R7: resizable mask is contiguous ones and at least 1 MB when live
    a_r7_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_RESIZE) |-> ((bar_mask & (bar_mask + 64'd1)) == 64'd0));
    a_r7_mask_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_RESIZE && bar_enabled) |-> (&bar_mask[MIN_LOG2-1:0]));

    // R9: an unsupported size request leaves the selection alone
    a_r9_bad_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (SCHEME == SCH_RESIZE && state_q == ST_LIVE && cfg_wr_en && !ro_wr_en
         && cfg_addr == REG_RSZ_CTL && !flags64[cfg_wdata[13:8]]) |=> $stable(sel_q));
endmodule

bind rbar_cfg_regs rbar_cfg_checker #(.SCHEME(SCHEME)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ro_wr_en    (ro_wr_en),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .bar_enabled (bar_enabled),
    .bar_mask    (bar_mask),
    .state_q     (state_q),
    .sup_q       (sup_q),
    .sel_q       (sel_q)
);

// File: tb/rbar_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module rbar_cfg_regs_tb_top;
    localparam logic [63:0] FM = 64'h0000_000F_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ro_wr_en = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        shd_wr_en = 1'b0;
    logic        shd_sel = 1'b0;
    logic [31:0] shd_wdata = 32'd0;

    logic [31:0] rd_r, rd_p, rd_f;
    logic        en_r, en_p, en_f;
    logic [63:0] mk_r, mk_p, mk_f;

    always #4 clk = ~clk;

    rbar_cfg_regs #(.SCHEME(2), .BAR_INDEX(3), .RSZ_BAR_COUNT(1)) dut_i (
        .clk, .rst_n, .ro_wr_en, .cfg_wr_en, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_r),
        .shd_wr_en, .shd_sel, .shd_wdata, .bar_enabled(en_r), .bar_mask(mk_r));
    rbar_cfg_regs #(.SCHEME(1)) dut_p (
        .clk, .rst_n, .ro_wr_en, .cfg_wr_en, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_p),
        .shd_wr_en, .shd_sel, .shd_wdata, .bar_enabled(en_p), .bar_mask(mk_p));
    rbar_cfg_regs #(.SCHEME(0), .FIXED_MASK(FM)) dut_f (
        .clk, .rst_n, .ro_wr_en, .cfg_wr_en, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_f),
        .shd_wr_en, .shd_sel, .shd_wdata, .bar_enabled(en_f), .bar_mask(mk_f));

    // ---------------- reference model ----------------
    logic [43:0] r_sup = '0;
    bit          r_en = 0, r_live = 0, r_pend = 0;
    int          r_sel = 0;
    logic [31:0] p_lo = '0, p_hi = '0;
    logic [3:0]  m_attr = '0;
    logic [27:0] m_blo = '0;
    logic [31:0] m_bhi = '0;
    bit          m_kick;
    int          m_k;

    function automatic int lowest(logic [43:0] f);
        for (int i = 0; i < 44; i++) if (f[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            r_sup = '0; r_en = 0; r_live = 0; r_pend = 0; r_sel = 0;
            p_lo = '0; p_hi = '0; m_attr = '0; m_blo = '0; m_bhi = '0;
        end else begin
            m_kick = (cfg_wr_en && ro_wr_en && (cfg_addr == 2'd2 || cfg_addr == 2'd3))
                     || (shd_wr_en && ro_wr_en && !shd_sel);
            if (r_pend) begin
                m_k = lowest(r_sup);
                if (m_k >= 0) r_sel = m_k;
                r_live = !m_kick && r_en && (m_k >= 0);
                r_pend = m_kick;
            end else if (m_kick) begin
                r_pend = 1; r_live = 0;
            end else if (r_live && cfg_wr_en && !ro_wr_en && cfg_addr == 2'd3) begin
                m_k = int'(cfg_wdata[13:8]);
                if (m_k < 44 && r_sup[m_k]) r_sel = m_k;
            end
            if (cfg_wr_en && cfg_addr == 2'd0) begin
                m_blo = cfg_wdata[31:4];
                if (ro_wr_en) m_attr = cfg_wdata[3:0];
            end
            if (cfg_wr_en && cfg_addr == 2'd1) m_bhi = cfg_wdata;
            if (cfg_wr_en && ro_wr_en && cfg_addr == 2'd2) r_sup[27:0] = cfg_wdata[31:4];
            if (cfg_wr_en && ro_wr_en && cfg_addr == 2'd3) r_sup[43:28] = cfg_wdata[31:16];
            if (shd_wr_en && ro_wr_en && !shd_sel) begin p_lo = shd_wdata; r_en = shd_wdata[0]; end
            if (shd_wr_en && ro_wr_en && shd_sel) p_hi = shd_wdata;
        end
    end

    function automatic bit exp_en(int s);
        if (s == 0) return 1;
        if (s == 1) return p_lo[0];
        return r_live;
    endfunction

    function automatic logic [63:0] exp_mask(int s);
        logic [63:0] m;
        bit w64;
        w64 = (m_attr[2:1] == 2'b10);
        if (!exp_en(s)) return 64'd0;
        if (s == 0)      m = FM;
        else if (s == 1) m = {p_hi, p_lo};
        else             m = (64'd1 << (20 + r_sel)) - 64'd1;
        if (!w64) m[63:32] = 32'd0;
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(int s, logic [1:0] a);
        logic [63:0] m;
        m = exp_mask(s);
        case (a)
            2'd0: return exp_en(s) ? (({m_blo, 4'b0} & ~m[31:0]) | {28'd0, m_attr}) : 32'd0;
            2'd1: return (exp_en(s) && m_attr[2:1] == 2'b10) ? (m_bhi & ~m[63:32]) : 32'd0;
            2'd2: return (s == 2) ? {r_sup[27:0], 4'b0} : 32'd0;
            default: return (s == 2) ? {r_sup[43:28], 2'b00, 6'(r_sel), 3'd1, 2'b00, 3'd3} : 32'd0;
        endcase
    endfunction

    // ---------------- checking ----------------
    int    n_vec = 0, n_bad = 0;
    string cur_req = "R11";
    bit    done = 0;

    task automatic chk64(string what, logic [63:0] got, logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %h expected %h", cur_req, what, $time, got, exp);
        end
    endtask

    task automatic compare();
        chk64("resize.en",   64'(en_r), 64'(exp_en(2)));
        chk64("resize.mask", mk_r, exp_mask(2));
        chk64("resize.rd",   64'(rd_r), 64'(exp_rd(2, cfg_addr)));
        chk64("prog.en",     64'(en_p), 64'(exp_en(1)));
        chk64("prog.mask",   mk_p, exp_mask(1));
        chk64("prog.rd",     64'(rd_p), 64'(exp_rd(1, cfg_addr)));
        chk64("fixed.en",    64'(en_f), 64'(exp_en(0)));   // R1
        chk64("fixed.mask",  mk_f, exp_mask(0));            // R1
        chk64("fixed.rd",    64'(rd_f), 64'(exp_rd(0, cfg_addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic cfgw(logic [1:0] a, logic [31:0] d, bit ro);
        cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d; ro_wr_en = ro;
        tick();
        cfg_wr_en = 0; ro_wr_en = 0;
    endtask

    task automatic shdw(bit hi, logic [31:0] d, bit ro);
        shd_wr_en = 1; shd_sel = hi; shd_wdata = d; ro_wr_en = ro;
        tick();
        shd_wr_en = 0; ro_wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a);
        cfg_addr = a;
        tick();
    endtask

    task automatic scan();
        for (int a = 0; a < 4; a++) rd(2'(a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        cur_req = "R11 reset";
        repeat (3) tick();
        rst_n = 1;
        scan();

        cur_req = "R4 locked cap write";
        cfgw(2'd2, 32'h0000_0010, 0);
        rd(2'd2);

        cur_req = "R4/R6 cap write sizes";
        cfgw(2'd2, 32'h0000_0050, 1);
        scan();

        cur_req = "R3 enable via shadow";
        shdw(0, 32'hFFFF_FFFF, 1);
        rd(2'd3); rd(2'd3); scan();

        cur_req = "R7 attributes and base";
        cfgw(2'd0, 32'hFFFF_FFFC, 1);
        cfgw(2'd1, 32'hFFFF_FFFF, 0);
        cfgw(2'd0, 32'h1234_5673, 0);
        scan();

        cur_req = "R9 select supported size";
        cfgw(2'd3, 32'h0000_0200, 0);
        scan();
        cur_req = "R9 unsupported size ignored";
        cfgw(2'd3, 32'h0000_0100, 0);
        rd(2'd3);
        cfgw(2'd3, 32'h0000_3200, 0);
        rd(2'd3); rd(2'd0);

        cur_req = "R5 upper flags unlocked";
        cfgw(2'd3, 32'h4000_0000, 1);
        cfgw(2'd2, 32'h0000_0000, 1);
        rd(2'd3); rd(2'd3); scan();
        cur_req = "R8 high word masked";
        cfgw(2'd1, 32'hFFFF_FFFF, 0);
        rd(2'd1);
        cur_req = "R5 locked control write";
        cfgw(2'd3, 32'hFFFF_0000, 0);
        rd(2'd3);

        cur_req = "R2 programmable high mask";
        shdw(1, 32'h0000_0003, 1);
        shdw(1, 32'h0000_00FF, 0);
        scan();

        cur_req = "R8 32-bit BAR";
        cfgw(2'd0, 32'h0000_0000, 1);
        scan();

        cur_req = "R6/R10 no size supported";
        cfgw(2'd3, 32'h0000_0000, 1);
        scan(); scan();

        cur_req = "R6 disable via shadow";
        cfgw(2'd2, 32'h0000_0100, 1);
        rd(2'd0); rd(2'd3);
        shdw(0, 32'h0000_0FFF, 1);
        scan();
        shdw(0, 32'h0000_0000, 1);
        scan();
        cur_req = "R2 shadow without unlock";
        shdw(0, 32'h0000_FFFF, 0);
        scan();

        cur_req = "R2/R3/R6/R9 mixed traffic";
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] v;
            op = int'($urandom % 7);
            v = $urandom;
            unique case (op)
                0: cfgw(2'd2, v & 32'h0124_0990, 1'($urandom % 4 != 0));
                1: cfgw(2'd3, {v[31:16] & 16'h0802, 2'b00, 6'($urandom % 48), 8'h00},
                        1'($urandom % 3 == 0));
                2: shdw(1'($urandom % 2), v, 1'($urandom % 3 != 0));
                3: cfgw(2'(v[1:0] == 2'd1 ? 1 : 0), v, 1'($urandom % 2));
                4: cfgw(2'd3, {16'h0, 2'b00, 6'($urandom % 44), 8'h00}, 0);
                default: rd(2'($urandom % 4));
            endcase
        end
        scan();
        finish_run();
    end
endmodule